// File: doc/BRIEF.md
# Event-Capture Timer with Time-of-Day Format

A 32-bit programmable timer behind a simple register read/write port. A tick source is chosen from the core clock or from rising edges on one of three asynchronous inputs (a slow crystal-derived clock and two general-purpose pins). The chosen ticks pass through a prescaler, and each divided tick steps the counter up or down. The counter runs free through its whole range or reloads from a load register whenever it reaches its terminal count. It raises an interrupt at every terminal count.

The count can be held as a plain binary number or as packed hours, minutes, seconds and hundredths. In the packed form, carries and borrows ripple between the fields, and hours wrap at either 23 or 255. A capture register watches one line of a system event bus and takes a snapshot of the count when that line pulses. Software can also read and write the capture register directly.

Top module: `evt_cap_timer`

## Requirements
- R1: After synchronous reset, the load, count, control and capture registers all read 0 and `irq` is low.
- R2: Register offsets on `bus_addr` are 0 for load, 1 for count (read-only, writes are ignored), 2 for control, 3 for interrupt clear and 4 for capture. `bus_rdata` presents the addressed register one cycle after the address is applied. A write to the load register also loads the counter with the written value.
- R3: The control word has these fields: bit 17 capture enable, bits 16:12 event select, bits 11:9 tick source, bit 8 direction (1 = up, 0 = down), bit 7 run, bit 6 mode (1 = periodic, 0 = free-running), bits 5:4 format and bits 3:0 prescale. Bits 31:18 read as 0.
- R4: The tick source is selected as follows. Code 000 gives one tick per core clock. Code 001 gives rising edges of `xtal_in`, code 010 rising edges of `pin_a` and code 011 rising edges of `pin_b`, each passed through a two-flop synchronizer. Codes 1xx produce no ticks. Edges on an input that is not selected have no effect.
- R5: The prescale code selects the division ratio. Code 0000 divides by 1, 0100 by 16, 1000 by 256 and 1111 by 32768. Any other code divides by 1. The prescaler restarts from zero while the timer is not running.
- R6: In binary format (format 00), a count up from 0xFFFFFFFF in free-running mode gives 0, and a count down from 0 gives 0xFFFFFFFF.
- R7: In periodic mode, a tick taken at the terminal count loads the counter from the load register. The terminal count is the all-ones value (binary, up), the format's maximum time (time format, up) or 0 (down).
- R8: Format 10 packs hundredths in bits 6:0 (0-99), seconds in bits 13:8, minutes in bits 21:16 and hours in bits 31:24, with hours wrapping at 23. Format 11 uses the same packing with hours wrapping at 255. Carries and borrows ripple through all the fields. Format 01 behaves as binary.
- R9: `irq` sets on every tick taken at the terminal count, in either mode. Any write to the clear register drops it.
- R10: When capture is enabled and event select is k, a pulse on `sys_evt[k+2]` copies the current count into the capture register. Pulses on other lines, or pulses while capture is disabled, leave the capture register unchanged.
- R11: While the run bit is 0, the counter holds its value whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| xtal_in | input | 1 | Slow crystal-derived clock, used as an edge source |
| pin_a | input | 1 | First general-purpose edge source |
| pin_b | input | 1 | Second general-purpose edge source |
| sys_evt | input | 34 | System event pulses; line k+2 is timer event k |
| irq | output | 1 | Terminal-count interrupt flag |

## Verification
The bench steps the counter one edge at a time through the pin sources, so every value it expects is exact. It targets the field roll-overs of the time format in both directions and at both hour ceilings. A design with a broken ripple would leave a field at 60 or 100, or would wrap the hours at the wrong ceiling. It also crosses the binary wrap and the periodic reload, where a wrong terminal test would miss the reload or the interrupt. It sweeps the prescaler ratios at their exact boundaries, where an off-by-one divider gains or loses a count. Finally, it pulses event lines next to the selected one and at the top index, so a design that forgets the offset of two captures on the wrong line.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW = 32;

  localparam logic [2:0] A_LOAD  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_CLR   = 3'd3;
  localparam logic [2:0] A_CAP   = 3'd4;

  localparam logic [2:0] SRC_CORE = 3'd0;
  localparam logic [2:0] SRC_XTAL = 3'd1;
  localparam logic [2:0] SRC_PINA = 3'd2;
  localparam logic [2:0] SRC_PINB = 3'd3;

  typedef struct packed {
    logic [13:0] rsvd;
    logic        cap_en;
    logic [4:0]  evt_sel;
    logic [2:0]  src;
    logic        up;
    logic        run;
    logic        periodic;
    logic [1:0]  fmt;
    logic [3:0]  psc;
  } ctrl_t;

  function automatic logic [CW-1:0] time_max(input logic [7:0] hmax);
    return {hmax, 2'b00, 6'd59, 2'b00, 6'd59, 1'b0, 7'd99};
  endfunction

  // One step of the packed time value with carry/borrow ripple.
  function automatic logic [CW-1:0] time_step(input logic [CW-1:0] v,
                                              input logic up,
                                              input logic [7:0] hmax);
    logic [6:0] hu;
    logic [5:0] se, mi;
    logic [7:0] hr;
    logic       c;
    hu = v[6:0]; se = v[13:8]; mi = v[21:16]; hr = v[31:24];
    c  = 1'b1;
    if (up) begin
      if (hu >= 7'd99) hu = 7'd0; else begin hu = hu + 7'd1; c = 1'b0; end
      if (c) begin
        if (se >= 6'd59) se = 6'd0; else begin se = se + 6'd1; c = 1'b0; end
      end
      if (c) begin
        if (mi >= 6'd59) mi = 6'd0; else begin mi = mi + 6'd1; c = 1'b0; end
      end
      if (c) begin
        if (hr >= hmax) hr = 8'd0; else hr = hr + 8'd1;
      end
    end else begin
      if (hu == 7'd0) hu = 7'd99;
      else begin hu = (hu > 7'd99) ? 7'd99 : hu - 7'd1; c = 1'b0; end
      if (c) begin
        if (se == 6'd0) se = 6'd59;
        else begin se = (se > 6'd59) ? 6'd59 : se - 6'd1; c = 1'b0; end
      end
      if (c) begin
        if (mi == 6'd0) mi = 6'd59;
        else begin mi = (mi > 6'd59) ? 6'd59 : mi - 6'd1; c = 1'b0; end
      end
      if (c) begin
        if (hr == 8'd0) hr = hmax;
        else hr = (hr > hmax) ? hmax : hr - 8'd1;
      end
    end
    return {hr, 2'b00, mi, 2'b00, se, 1'b0, hu};
  endfunction
endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src #(
  parameter int NSYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] async_in,
  input  logic [2:0] src,
  input  logic       run,
  output logic       src_tick
);
  import tmr_pkg::*;
  localparam int NASY = 3;

  logic [NASY-1:0] rise;

  for (genvar i = 0; i < NASY; i++) begin : g_sync
    logic [NSYNC-1:0] sh;
    logic             last;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        last <= 1'b0;
      end else begin
        sh   <= {sh[NSYNC-2:0], async_in[i]};
        last <= sh[NSYNC-1];
      end
    end
    assign rise[i] = sh[NSYNC-1] & ~last;
  end

  always_comb begin
    case (src)
      SRC_CORE: src_tick = run;
      SRC_XTAL: src_tick = run & rise[0];
      SRC_PINA: src_tick = run & rise[1];
      SRC_PINB: src_tick = run & rise[2];
      default:  src_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DW = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       src_tick,
  input  logic [3:0] psc,
  output logic       cnt_tick
);
  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_last;

  always_comb begin
    case (psc)
      4'b0100: div_last = DW'(15);
      4'b1000: div_last = DW'(255);
      4'b1111: div_last = DW'(32767);
      default: div_last = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) div_cnt <= '0;
    else if (src_tick) div_cnt <= (div_cnt >= div_last) ? '0 : div_cnt + 1'b1;
  end

  assign cnt_tick = src_tick & (div_cnt >= div_last);
endmodule

// File: rtl/tmr_count.sv
module tmr_count (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld,
  input  logic [tmr_pkg::CW-1:0] ld_val,
  input  logic [tmr_pkg::CW-1:0] reload_val,
  input  logic                 tick,
  input  logic                 up,
  input  logic                 periodic,
  input  logic [1:0]           fmt,
  output logic [tmr_pkg::CW-1:0] cnt,
  output logic                 tc_tick
);
  import tmr_pkg::*;

  logic          is_time;
  logic [7:0]    hmax;
  logic [CW-1:0] tc_val;
  logic [CW-1:0] step_val;
  logic          at_tc;

  assign is_time = fmt[1];
  assign hmax    = fmt[0] ? 8'd255 : 8'd23;

  always_comb begin
    if (!up)          tc_val = '0;
    else if (is_time) tc_val = time_max(hmax);
    else              tc_val = '1;
    step_val = is_time ? time_step(cnt, up, hmax)
                       : (up ? cnt + 1'b1 : cnt - 1'b1);
  end

  assign at_tc   = (cnt == tc_val);
  assign tc_tick = tick & at_tc;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (ld)                    cnt <= ld_val;
    else if (tick && at_tc && periodic) cnt <= reload_val;
    else if (tick)                  cnt <= step_val;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt)); // R11
  AST_TIME_FIELDS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && is_time && !(at_tc && periodic)) |=>
      (cnt[6:0] <= 7'd99 && cnt[13:8] <= 6'd59 && cnt[21:16] <= 6'd59)); // R8
endmodule

// File: rtl/evt_cap_timer.sv
module evt_cap_timer #(
  parameter int EVT_OFS     = 2,
  parameter int EVT_N       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 15,
  localparam int SYS_N      = EVT_N + EVT_OFS,
  localparam int SYS_IW     = $clog2(SYS_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             xtal_in,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic [SYS_N-1:0] sys_evt,
  output logic             irq
);
  import tmr_pkg::*;

  ctrl_t         ctrl_q;
  logic [CW-1:0] load_q;
  logic [CW-1:0] cap_q;
  logic [CW-1:0] cnt;
  logic          src_tick, cnt_tick, tc_tick;
  logic          wr_load, wr_ctrl, wr_clr, wr_cap;
  logic [SYS_IW-1:0] evt_idx;
  logic          cap_hit;

  assign wr_load = bus_we && bus_addr == A_LOAD;
  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign wr_clr  = bus_we && bus_addr == A_CLR;
  assign wr_cap  = bus_we && bus_addr == A_CAP;

  tmr_tick_src #(.NSYNC(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .async_in({pin_b, pin_a, xtal_in}),
    .src(ctrl_q.src), .run(ctrl_q.run), .src_tick(src_tick));

  tmr_prescale #(.DW(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .src_tick(src_tick),
    .psc(ctrl_q.psc), .cnt_tick(cnt_tick));

  tmr_count u_cnt (
    .clk(clk), .rst(rst), .ld(wr_load), .ld_val(bus_wdata),
    .reload_val(load_q), .tick(cnt_tick), .up(ctrl_q.up),
    .periodic(ctrl_q.periodic), .fmt(ctrl_q.fmt), .cnt(cnt),
    .tc_tick(tc_tick));

  assign evt_idx = SYS_IW'(ctrl_q.evt_sel) + SYS_IW'(EVT_OFS);
  assign cap_hit = ctrl_q.cap_en && sys_evt[evt_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      cap_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q      <= ctrl_t'(bus_wdata);
        ctrl_q.rsvd <= '0;
      end
      if (wr_load) load_q <= bus_wdata;
      if (cap_hit)     cap_q <= cnt;
      else if (wr_cap) cap_q <= bus_wdata;
      if (tc_tick)     irq <= 1'b1;
      else if (wr_clr) irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_LOAD:  bus_rdata <= load_q;
        A_COUNT: bus_rdata <= cnt;
        A_CTRL:  bus_rdata <= ctrl_q;
        A_CAP:   bus_rdata <= cap_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_IRQ_FROM_TC: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tc_tick)); // R9
  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !tc_tick) |=> !irq); // R9
  AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (rst)
    cap_hit |=> (cap_q == $past(cnt))); // R10
  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_load) |=> $stable(cnt)); // R11
endmodule

// File: tb/sim_evt_cap_timer.sv
module sim_evt_cap_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xtal_in = 1'b0, pin_a = 1'b0, pin_b = 1'b0;
  logic [33:0] sys_evt = '0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          rd_pending = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  evt_cap_timer u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xtal_in(xtal_in),
    .pin_a(pin_a), .pin_b(pin_b), .sys_evt(sys_evt), .irq(irq));

  localparam logic [2:0] LD = 0, CNT = 1, CTL = 2, CLR = 3, CAP = 4;

  function automatic logic [31:0] mk(input logic cap, input logic [4:0] sel,
      input logic [2:0] src, input logic up, input logic run,
      input logic per, input logic [1:0] fmt, input logic [3:0] psc);
    return {14'b0, cap, sel, src, up, run, per, fmt, psc};
  endfunction

  // Monitor: compares the read data one edge after each request.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rd_pending) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
        rd_pending = 0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_pending = 1;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic setup(input logic [31:0] ld, input logic [31:0] c);
    wr(CTL, 32'h0);
    wr(CLR, 32'h0);
    wr(LD, ld);
    wr(CTL, c);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: xtal_in = 1'b1;
      1: pin_a = 1'b1;
      default: pin_b = 1'b1;
    endcase
    repeat (4) @(negedge clk);
    xtal_in = 1'b0; pin_a = 1'b0; pin_b = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic evt(input int line);
    sys_evt[line] = 1'b1;
    @(negedge clk);
    sys_evt = '0;
  endtask

  task automatic finish_up;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    expect_rd(LD,  32'h0, "R1 load");
    expect_rd(CNT, 32'h0, "R1 count");
    expect_rd(CTL, 32'h0, "R1 ctrl");
    expect_rd(CAP, 32'h0, "R1 capture");
    chk_irq(1'b0, "R1 irq");

    // R2 load also loads counter; count register ignores writes
    wr(LD, 32'h0000_1234);
    expect_rd(CNT, 32'h0000_1234, "R2 load sets count");
    wr(CNT, 32'hDEAD_BEEF);
    expect_rd(CNT, 32'h0000_1234, "R2 count write ignored");
    // R3 control readback masks reserved bits
    wr(CTL, 32'hFFFF_FF7F);
    expect_rd(CTL, 32'h0003_FF7F, "R3 ctrl fields");

    // R4 pin A up binary
    setup(32'd10, mk(0, 0, 3'd2, 1, 1, 0, 2'b00, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'd11, "R4 pin A edge");
    pulse(2);
    expect_rd(CNT, 32'd11, "R4 pin B ignored on pin A source");
    // R4 xtal source
    setup(32'd10, mk(0, 0, 3'd1, 1, 1, 0, 2'b00, 4'b0000));
    pulse(0);
    pulse(0);
    expect_rd(CNT, 32'd12, "R4 xtal edges");
    // R4 pin B source, pin A ignored
    setup(32'd10, mk(0, 0, 3'd3, 0, 1, 0, 2'b00, 4'b0000));
    pulse(1);
    pulse(2);
    expect_rd(CNT, 32'd9, "R4 pin B down");
    // R4 reserved source
    setup(32'd10, mk(0, 0, 3'd4, 1, 1, 0, 2'b00, 4'b0000));
    repeat (20) @(negedge clk);
    pulse(1);
    expect_rd(CNT, 32'd10, "R4 reserved source no ticks");

    // R11 stopped timer holds
    setup(32'd7, mk(0, 0, 3'd2, 1, 0, 0, 2'b00, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'd7, "R11 stopped holds");

    // R4/R5 core clock, divide by 1: enable for 10 edges
    setup(32'd100, mk(0, 0, 3'd0, 0, 1, 0, 2'b00, 4'b0000));
    repeat (9) @(negedge clk);
    wr(CTL, 32'h0);
    expect_rd(CNT, 32'd90, "R5 core clock div1");
    // R5 divide by 256 over 600 edges -> 2
    setup(32'd0, mk(0, 0, 3'd0, 1, 1, 0, 2'b00, 4'b1000));
    repeat (599) @(negedge clk);
    wr(CTL, 32'h0);
    expect_rd(CNT, 32'd2, "R5 div256");
    // R5 divide by 32768 over 32768 edges -> 1
    setup(32'd0, mk(0, 0, 3'd0, 1, 1, 0, 2'b00, 4'b1111));
    repeat (32767) @(negedge clk);
    wr(CTL, 32'h0);
    expect_rd(CNT, 32'd1, "R5 div32768");
    // R5 divide by 16 with pin edges
    setup(32'd0, mk(0, 0, 3'd2, 1, 1, 0, 2'b00, 4'b0100));
    for (int i = 0; i < 15; i++) pulse(1);
    expect_rd(CNT, 32'd0, "R5 div16 after 15");
    pulse(1);
    expect_rd(CNT, 32'd1, "R5 div16 after 16");
    // R5 reserved code divides by 1
    setup(32'd0, mk(0, 0, 3'd2, 1, 1, 0, 2'b00, 4'b0011));
    pulse(1);
    expect_rd(CNT, 32'd1, "R5 reserved prescale");

    // R6 binary wraps and R9 interrupt
    setup(32'd0, mk(0, 0, 3'd2, 0, 1, 0, 2'b00, 4'b0000));
    chk_irq(1'b0, "R9 irq clear before tc");
    pulse(1);
    expect_rd(CNT, 32'hFFFF_FFFF, "R6 down wrap");
    chk_irq(1'b1, "R9 irq at down tc");
    wr(CLR, 32'h5A);
    chk_irq(1'b0, "R9 clear write drops irq");
    setup(32'hFFFF_FFFF, mk(0, 0, 3'd2, 1, 1, 0, 2'b00, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h0, "R6 up wrap");
    chk_irq(1'b1, "R9 irq at up tc");

    // R7 periodic down reload
    setup(32'd2, mk(0, 0, 3'd2, 0, 1, 1, 2'b00, 4'b0000));
    pulse(1);
    pulse(1);
    expect_rd(CNT, 32'd0, "R7 reached zero");
    chk_irq(1'b0, "R9 no irq before tick at tc");
    pulse(1);
    expect_rd(CNT, 32'd2, "R7 periodic reload");
    chk_irq(1'b1, "R9 irq on reload");
    // R7 periodic up reload from all-ones
    setup(32'hFFFF_FFFE, mk(0, 0, 3'd2, 1, 1, 1, 2'b00, 4'b0000));
    pulse(1);
    pulse(1);
    expect_rd(CNT, 32'hFFFF_FFFE, "R7 periodic up reload");

    // R8 time format
    setup(32'h173B_3B63, mk(0, 0, 3'd2, 1, 1, 0, 2'b10, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h0000_0000, "R8 23h ceiling up wrap");
    chk_irq(1'b1, "R9 irq at time tc");
    setup(32'h173B_3B63, mk(0, 0, 3'd2, 1, 1, 0, 2'b11, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h1800_0000, "R8 255h hour carry");
    setup(32'h0, mk(0, 0, 3'd2, 0, 1, 0, 2'b10, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h173B_3B63, "R8 23h down borrow");
    setup(32'h0, mk(0, 0, 3'd2, 0, 1, 0, 2'b11, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'hFF3B_3B63, "R8 255h down borrow");
    setup(32'h0000_3B63, mk(0, 0, 3'd2, 1, 1, 0, 2'b10, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h0001_0000, "R8 minute carry");
    wr(CTL, mk(0, 0, 3'd2, 0, 1, 0, 2'b10, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h0000_3B63, "R8 minute borrow");
    setup(32'h0000_0063, mk(0, 0, 3'd2, 1, 1, 0, 2'b01, 4'b0000));
    pulse(1);
    expect_rd(CNT, 32'h0000_0064, "R8 reserved format is binary");

    // R10 capture
    setup(32'h55, mk(1, 5'd5, 3'd4, 0, 0, 0, 2'b00, 4'b0000));
    evt(7);
    expect_rd(CAP, 32'h55, "R10 capture on line sel+2");
    wr(LD, 32'h66);
    evt(5);
    evt(6);
    expect_rd(CAP, 32'h55, "R10 other lines ignored");
    wr(CTL, mk(0, 5'd5, 3'd4, 0, 0, 0, 2'b00, 4'b0000));
    evt(7);
    expect_rd(CAP, 32'h55, "R10 disabled capture ignored");
    wr(CAP, 32'hABCD);
    expect_rd(CAP, 32'hABCD, "R10 capture writable");
    wr(CTL, mk(1, 5'd31, 3'd4, 0, 0, 0, 2'b00, 4'b0000));
    evt(33);
    expect_rd(CAP, 32'h66, "R10 top event index");

    done = 1;
    finish_up();
  end
endmodule